// File: doc/BRIEF.md
# Program Counter Sequencer with Flag-Conditioned Relative Jumps

This block owns the instruction address of a small processor. Every clock edge on which the control logic raises the write enable, it loads one of two candidates. The sequential candidate is the current address plus one. The jump candidate is that same sequential address plus a signed offset taken from the instruction. A three-bit jump code picks the rule. The rule is either "never jump", "always jump", or one of five tests on the zero and carry flags left by the last compare.

The control unit drives the write enable in the final state of each instruction. The datapath presents the offset field and the flags. The instruction memory reads `pc_addr` directly. All of these pins are plain control and status signals with no handshake. Instruction memory and flag generation sit outside this block.

Top module: `pcseq_top`

## Requirements
- R1: A clock edge with `rst_n` low sets `pc_addr` to 0. The address reads 0 on the first edge after `rst_n` returns high.
- R2: While `pc_we` is low, `pc_addr` keeps its value on every edge, whatever the jump code, offset and flags are.
- R3: With `pc_we` high and jump code 0 (no jump), the next address is `pc_addr`+1 modulo 1024, so 1023 is followed by 0.
- R4: With `pc_we` high and jump code 1 (unconditional), the next address is (`pc_addr`+1+offset) modulo 1024. The offset is the two's-complement value of `jmp_ofs`, sign-extended. For example, +3 lands three past the following instruction and -5 lands five before it.
- R5: Jump code 2 (equal) takes the jump only when `flag_z`=1 and `flag_c`=0. Otherwise it loads `pc_addr`+1.
- R6: Jump code 3 (above) takes the jump only when `flag_z`=0 and `flag_c`=0. Otherwise it loads `pc_addr`+1.
- R7: Jump code 4 (below) takes the jump only when `flag_z`=0 and `flag_c`=1. Otherwise it loads `pc_addr`+1.
- R8: Jump code 5 (above or equal) takes the jump whenever `flag_c`=0. Otherwise it loads `pc_addr`+1.
- R9: Jump code 6 (below or equal) takes the jump whenever `flag_c`=1 or `flag_z`=1. Otherwise it loads `pc_addr`+1.
- R10: Jump code 7 is unused and behaves like code 0, loading `pc_addr`+1.
- R11: Extreme offsets wrap modulo 1024. Offset -128 from a low address lands near the top of the space, and offset +127 from near the top lands near the bottom.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_we | input | 1 | Load enable for the address register |
| jmp_kind | input | 3 | Jump rule: 0 none, 1 always, 2 equal, 3 above, 4 below, 5 above-or-equal, 6 below-or-equal, 7 unused |
| jmp_ofs | input | OFS_W (8) | Signed relative offset, two's complement |
| flag_z | input | 1 | Zero flag from the last compare |
| flag_c | input | 1 | Carry (borrow) flag from the last compare |
| pc_addr | output | ADDR_W (10) | Current instruction address |

## Verification
The address register is the only state in the block, so any internal fault shows directly on `pc_addr` on the edge where it happens. A wrongly decoded condition gives an address that differs by exactly the offset on the first edge that presents that code and flag pair. Stepping every jump code through all four flag combinations exposes a wrong condition within one cycle. A sign-extension or wrap fault appears only for negative or edge-of-range offsets, so those cases are driven deliberately.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    JK_NONE   = 3'd0,
    JK_ALWAYS = 3'd1,
    JK_EQ     = 3'd2,
    JK_ABOVE  = 3'd3,
    JK_BELOW  = 3'd4,
    JK_AE     = 3'd5,
    JK_BE     = 3'd6,
    JK_RSVD   = 3'd7
  } jump_kind_e;
endpackage

// File: rtl/pcseq_cond.sv
// Decides whether the selected jump rule is satisfied by the flag pair.
module pcseq_cond
  import pcseq_pkg::*;
(
  input  jump_kind_e kind,
  input  logic       zf,
  input  logic       cf,
  output logic       take
);
  always_comb begin
    case (kind)
      JK_ALWAYS: take = 1'b1;
      JK_EQ:     take = zf & ~cf;
      JK_ABOVE:  take = ~zf & ~cf;
      JK_BELOW:  take = ~zf & cf;
      JK_AE:     take = ~cf;
      JK_BE:     take = cf | zf;
      default:   take = 1'b0;   // none and unused code fall through
    endcase
  end
endmodule

// File: rtl/pcseq_target.sv
// Forms the sequential address and the relative jump address.
module pcseq_target #(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] seq,
  output logic [ADDR_W-1:0] tgt
);
  logic [ADDR_W-1:0] ofs_ext;

  generate
    if (OFS_W >= ADDR_W) begin : g_trunc
      assign ofs_ext = ofs[ADDR_W-1:0];
    end else begin : g_sext
      localparam int PAD_W = ADDR_W - OFS_W;
      assign ofs_ext = {{PAD_W{ofs[OFS_W-1]}}, ofs};
    end
  endgenerate

  assign seq = pc + ADDR_W'(1);
  assign tgt = seq + ofs_ext;
endmodule

// File: rtl/pcseq_reg.sv
// Address register with the sequential / jump select.
module pcseq_reg #(
  parameter int                ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              take,
  input  logic [ADDR_W-1:0] seq,
  input  logic [ADDR_W-1:0] tgt,
  output logic [ADDR_W-1:0] pc
);
  logic [ADDR_W-1:0] pc_nxt;

  assign pc_nxt = take ? tgt : seq;

  always_ff @(posedge clk) begin
    if (!rst_n)  pc <= RESET_PC;
    else if (we) pc <= pc_nxt;
  end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_we,
  input  logic [KIND_W-1:0] jmp_kind,
  input  logic [OFS_W-1:0]  jmp_ofs,
  input  logic              flag_z,
  input  logic              flag_c,
  output logic [ADDR_W-1:0] pc_addr
);
  jump_kind_e        kind;
  logic              take;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] tgt_addr;

  assign kind = jump_kind_e'(jmp_kind);

  pcseq_cond u_cond (
    .kind (kind),
    .zf   (flag_z),
    .cf   (flag_c),
    .take (take)
  );

  pcseq_target #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_target (
    .pc  (pc_addr),
    .ofs (jmp_ofs),
    .seq (seq_addr),
    .tgt (tgt_addr)
  );

  pcseq_reg #(.ADDR_W(ADDR_W), .RESET_PC('0)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pc_we),
    .take  (take),
    .seq   (seq_addr),
    .tgt   (tgt_addr),
    .pc    (pc_addr)
  );
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pc_we,
  input logic [2:0]        jmp_kind,
  input logic [OFS_W-1:0]  jmp_ofs,
  input logic              flag_z,
  input logic              flag_c,
  input logic [ADDR_W-1:0] pc_addr
);
  logic [ADDR_W-1:0] inc_c;
  logic [ADDR_W-1:0] jmp_c;
  logic              upd;

  assign inc_c = pc_addr + ADDR_W'(1);
  assign jmp_c = inc_c + ADDR_W'($signed(jmp_ofs));
  assign upd   = rst_n & pc_we;

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc_addr == '0);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(pc_we)) |-> $stable(pc_addr));

  assert_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(jmp_kind) == 3'd0) |-> pc_addr == $past(inc_c));

  assert_always_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(jmp_kind) == 3'd1) |-> pc_addr == $past(jmp_c));

  assert_eq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(jmp_kind) == 3'd2) |->
      pc_addr == ($past(flag_z && !flag_c) ? $past(jmp_c) : $past(inc_c)));

  assert_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(jmp_kind) == 3'd3) |->
      pc_addr == ($past(!flag_z && !flag_c) ? $past(jmp_c) : $past(inc_c)));

  assert_below_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(jmp_kind) == 3'd4) |->
      pc_addr == ($past(!flag_z && flag_c) ? $past(jmp_c) : $past(inc_c)));

  assert_ae_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(jmp_kind) == 3'd5) |->
      pc_addr == ($past(!flag_c) ? $past(jmp_c) : $past(inc_c)));

  assert_be_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(jmp_kind) == 3'd6) |->
      pc_addr == ($past(flag_c || flag_z) ? $past(jmp_c) : $past(inc_c)));

  assert_unused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(jmp_kind) == 3'd7) |-> pc_addr == $past(inc_c));
endmodule

bind pcseq_top pcseq_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pc_we    (pc_we),
  .jmp_kind (jmp_kind),
  .jmp_ofs  (jmp_ofs),
  .flag_z   (flag_z),
  .flag_c   (flag_c),
  .pc_addr  (pc_addr)
);

// File: tb/pcseq_top_bench.sv
module pcseq_top_bench;
  localparam int ADDR_W = 10;
  localparam int OFS_W  = 8;
  localparam int SPACE  = 1 << ADDR_W;

  typedef struct {
    int    exp;
    string tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pc_we = 1'b0;
  logic [2:0]        jmp_kind = 3'd0;
  logic [OFS_W-1:0]  jmp_ofs = '0;
  logic              flag_z = 1'b0;
  logic              flag_c = 1'b0;
  logic [ADDR_W-1:0] pc_addr;

  item_t q[$];
  int    model_pc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  pcseq_top u_pcseq_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_we    (pc_we),
    .jmp_kind (jmp_kind),
    .jmp_ofs  (jmp_ofs),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .pc_addr  (pc_addr)
  );

  function automatic bit cond_ok(input int k, input bit z, input bit c);
    case (k)
      1:       return 1'b1;            // R4
      2:       return z && !c;         // R5
      3:       return !z && !c;        // R6
      4:       return !z && c;         // R7
      5:       return !c;              // R8
      6:       return c || z;          // R9
      default: return 1'b0;            // R3, R10
    endcase
  endfunction

  function automatic int wrap(input int v);
    return ((v % SPACE) + SPACE) % SPACE;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected address.
  task automatic step(input bit we, input int k, input int ofs, input bit z,
                      input bit c, input string tag);
    item_t it;
    @(negedge clk);
    pc_we    = we;
    jmp_kind = 3'(k);
    jmp_ofs  = OFS_W'(ofs);
    flag_z   = z;
    flag_c   = c;
    if (we) model_pc = cond_ok(k, z, c) ? wrap(model_pc + 1 + ofs) : wrap(model_pc + 1);
    it.exp = model_pc;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic do_reset();
    item_t it;
    @(negedge clk);
    rst_n = 1'b0;
    pc_we = 1'b1;
    jmp_kind = 3'd1;
    jmp_ofs = OFS_W'(9);
    model_pc = 0;
    it.exp = 0;
    it.tag = "R1";
    q.push_back(it);
    @(negedge clk);
    rst_n = 1'b1;
    pc_we = 1'b0;
  endtask

  // Monitor: compares the address shortly after each rising edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (int'(pc_addr) != it.exp) begin
        n_bad++;
        $display("FAIL %s: pc_addr=%0d expected=%0d", it.tag, pc_addr, it.exp);
      end
    end
  end

  initial begin
    do_reset();                                     // R1
    step(1, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, "R3");
    step(0, 1, 50, 1, 1, "R2");                     // enable low: no move
    step(0, 0, 0, 0, 0, "R2");
    step(1, 1, 3, 0, 0, "R4 fwd");
    step(1, 1, -5, 1, 1, "R4 back");
    step(1, 1, 20, 0, 0, "R4");
    for (int k = 2; k <= 7; k++) begin
      for (int f = 0; f < 4; f++) begin
        string t;
        case (k)
          2: t = "R5"; 3: t = "R6"; 4: t = "R7";
          5: t = "R8"; 6: t = "R9"; default: t = "R10";
        endcase
        step(1, k, 4 + f, f[1], f[0], t);
      end
    end
    do_reset();                                     // R1 again
    step(1, 1, -128, 0, 0, "R11 neg wrap");         // 0+1-128 -> 897
    step(1, 1, 125, 0, 0, "R11");                   // 897+1+125 -> 1023
    step(1, 0, 0, 0, 0, "R3 wrap");                 // 1023 -> 0
    step(1, 1, -2, 0, 0, "R11");                    // 0+1-2 -> 1023
    step(1, 1, 127, 0, 0, "R11 pos wrap");          // 1023+1+127 -> 127
    step(1, 6, -100, 1, 0, "R9");
    step(1, 8'd0, 0, 0, 0, "R3");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule